// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counting Timer

This block is a general-purpose timer with two independent 16-bit channels. Both channels run from one shared functional clock. Each channel has its own prescaler, which divides that clock by a power of two from 1 to 256. On every prescaled tick the channel's counter counts down from a programmed start value. When the count runs out, the channel raises an interrupt status bit. It then either reloads and keeps running, or stops after that single expiry, depending on a mode bit.

Software drives the block through a simple single-cycle register port made of an address, write data, a write strobe and read data that settles in the same cycle. Each channel occupies one window of four registers: control, interrupt status, start value and current count. The count can be read at any moment. Each channel's interrupt line is the level of its status bit, gated by that channel's interrupt enable. Software acknowledges an expiry by writing a one to the status bit.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every register of both channels reads 0 and both interrupt outputs are low.
- R2: Channel n (n = 0, 1) decodes its registers at byte offsets 0x80 + n*0x80 plus 0x0 (control), 0x4 (status), 0x8 (start value) and 0xC (count). Any other address reads 0, and a write to one channel leaves the other channel unchanged.
- R3: Control bits [3:0] hold a prescaler code c. With the channel enabled and start value L, the status bit sets exactly L*2^c clock edges after the edge that wrote the enable bit, for c = 0..8.
- R4: The count register reads L - k after k prescaled ticks and changes only on a tick or on a write to the start value.
- R5: When the one-shot bit (control bit 4) is 0, expiry reloads the count with the start value, the channel keeps running, and the next expiry follows after another L*2^c edges.
- R6: When the one-shot bit is 1, expiry clears the enable bit (control bit 5). The count then stays at 0 and no further expiry occurs.
- R7: Status bit 0 sets on expiry. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: The interrupt output of a channel equals its status bit ANDed with its interrupt-enable bit (control bit 8). Status still sets when the interrupt enable is 0.
- R9: The two channels count independently and at the same time, each with its own prescaler code and start value.
- R10: Writing the start value while a channel runs restarts both its count and its prescaler, so expiry follows L_new*2^c edges after that write.
- R11: Prescaler codes 9 to 15 are stored and read back as written, but divide by 256.
- R12: Control bits other than 8, 5, 4 and 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 10 | Byte address of the register access |
| busWdata | input | 16 | Write data |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busRdata | output | 16 | Read data for busAddr, valid in the same cycle |
| irqOut | output | 2 | Per-channel interrupt level, bit n for channel n |

## Verification
A wrong divider phase or wrong code decoding moves the expiry by whole ticks. That error shows up on the interrupt line within L*2^c cycles of enabling the channel, so the bench sweeps every prescaler code with several start values and compares the exact edge count against L*2^c. A stale or misloaded counter shows up straight away on the count register, which is readable at any time. A one-shot channel that fails to stop shows up as an enable bit that still reads 1, or as a status bit that sets again after it was cleared. Cross-channel decode faults show up as values read back from the wrong window or as an interrupt on the wrong line.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Register select within a channel window (address bits [3:2])
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_STAT  = 2'd1;
  localparam logic [1:0] REG_LOAD  = 2'd2;
  localparam logic [1:0] REG_COUNT = 2'd3;

  // Control field positions
  localparam int BIT_ONESHOT = 4;
  localparam int BIT_ENABLE  = 5;
  localparam int BIT_INTEN   = 8;

  // Log2 of the channel window stride (0x80)
  localparam int WIN_SHIFT = 7;

  // Write strobes from the decoder to one channel datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic wrLoad;
  } chStrobe_t;

endpackage

// File: rtl/timer_ctl.sv
module timer_ctl
  import timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 10,
  localparam int WIN_W = ADDR_W - WIN_SHIFT,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output chStrobe_t         strb [NUM_CH],
  output logic [CH_W-1:0]   rdSel,
  output logic [1:0]        rdReg,
  output logic              rdHit
);

  logic [WIN_W-1:0]  win;
  logic              inWin;
  logic [NUM_CH-1:0] chHit;

  assign win   = busAddr[ADDR_W-1:WIN_SHIFT];
  assign inWin = (busAddr[WIN_SHIFT-1:4] == '0) && (busAddr[1:0] == 2'b00);
  assign rdReg = busAddr[3:2];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign chHit[g]       = inWin && (win == WIN_W'(g + 1));
    assign strb[g].wrCtrl = busWe && chHit[g] && (rdReg == REG_CTRL);
    assign strb[g].wrStat = busWe && chHit[g] && (rdReg == REG_STAT);
    assign strb[g].wrLoad = busWe && chHit[g] && (rdReg == REG_LOAD);
  end

  assign rdHit = |chHit;

  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chHit[i]) rdSel = CH_W'(i);
    end
  end

endmodule

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 8,
  localparam int PRE_W   = (MAX_CODE > 0) ? MAX_CODE : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [CODE_W-1:0] effCode;
  logic [PRE_W-1:0]  mask;
  logic [PRE_W-1:0]  preCnt;

  // Codes above the largest supported divide as the largest
  assign effCode = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;

  always_comb begin
    for (int b = 0; b < PRE_W; b++) begin
      mask[b] = (CODE_W'(b) < effCode);
    end
  end

  assign tick = run && ((preCnt & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (!run || restart) preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrlRd,
  output logic              statusBit,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  countVal,
  output logic              enOut,
  output logic              oneShotOut,
  output logic              irq
);

  logic [CODE_W-1:0] code;
  logic              oneShot;
  logic              enable;
  logic              intEn;
  logic              status;
  logic [CNT_W-1:0]  loadReg;
  logic [CNT_W-1:0]  count;
  logic              tick;
  logic              restart;
  logic              expire;

  assign restart = strb.wrLoad || (strb.wrCtrl && wdata[BIT_ENABLE] && !enable);
  assign expire  = tick && (count <= CNT_W'(1));

  timer_prescale #(
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE)
  ) u_pre (
    .clk     (clk),
    .rstN    (rstN),
    .run     (enable),
    .restart (restart),
    .code    (code),
    .tick    (tick)
  );

  // Control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code    <= '0;
      oneShot <= 1'b0;
      enable  <= 1'b0;
      intEn   <= 1'b0;
    end else if (strb.wrCtrl) begin
      code    <= wdata[CODE_W-1:0];
      oneShot <= wdata[BIT_ONESHOT];
      enable  <= wdata[BIT_ENABLE];
      intEn   <= wdata[BIT_INTEN];
    end else if (expire && oneShot) begin
      enable  <= 1'b0;
    end
  end

  // Start value and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadReg <= '0;
      count   <= '0;
    end else if (strb.wrLoad) begin
      loadReg <= wdata[CNT_W-1:0];
      count   <= wdata[CNT_W-1:0];
    end else if (expire) begin
      count   <= oneShot ? '0 : loadReg;
    end else if (tick) begin
      count   <= count - 1'b1;
    end
  end

  // Interrupt status: expiry wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          status <= 1'b0;
    else if (expire)                    status <= 1'b1;
    else if (strb.wrStat && wdata[0])   status <= 1'b0;
  end

  always_comb begin
    ctrlRd              = '0;
    ctrlRd[CODE_W-1:0]  = code;
    ctrlRd[BIT_ONESHOT] = oneShot;
    ctrlRd[BIT_ENABLE]  = enable;
    ctrlRd[BIT_INTEN]   = intEn;
  end

  assign statusBit  = status;
  assign loadVal    = loadReg;
  assign countVal   = count;
  assign enOut      = enable;
  assign oneShotOut = oneShot;
  assign irq        = status && intEn;

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import timer_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqOut
);

  chStrobe_t                      strb [NUM_CH];
  logic [CH_W-1:0]                rdSel;
  logic [1:0]                     rdReg;
  logic                           rdHit;
  logic [DATA_W-1:0]              chCtrl [NUM_CH];
  logic [NUM_CH-1:0]              chStatus;
  logic [NUM_CH-1:0]              chEn;
  logic [NUM_CH-1:0]              chOneShot;
  logic [NUM_CH-1:0][CNT_W-1:0]   chLoad;
  logic [NUM_CH-1:0][CNT_W-1:0]   chCount;

  timer_ctl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_ctl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb),
    .rdSel   (rdSel),
    .rdReg   (rdReg),
    .rdHit   (rdHit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    timer_chan #(
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W),
      .CODE_W   (CODE_W),
      .MAX_CODE (MAX_CODE)
    ) u_chan (
      .clk        (clk),
      .rstN       (rstN),
      .strb       (strb[g]),
      .wdata      (busWdata),
      .ctrlRd     (chCtrl[g]),
      .statusBit  (chStatus[g]),
      .loadVal    (chLoad[g]),
      .countVal   (chCount[g]),
      .enOut      (chEn[g]),
      .oneShotOut (chOneShot[g]),
      .irq        (irqOut[g])
    );
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      case (rdReg)
        REG_CTRL:  busRdata = chCtrl[rdSel];
        REG_STAT:  busRdata = DATA_W'(chStatus[rdSel]);
        REG_LOAD:  busRdata = DATA_W'(chLoad[rdSel]);
        default:   busRdata = DATA_W'(chCount[rdSel]);
      endcase
    end
  end

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         busWe,
  input logic [NUM_CH-1:0]            irqOut,
  input logic [NUM_CH-1:0]            chStatus,
  input logic [NUM_CH-1:0]            chEn,
  input logic [NUM_CH-1:0]            chOneShot,
  input logic [NUM_CH-1:0][CNT_W-1:0] chLoad,
  input logic [NUM_CH-1:0][CNT_W-1:0] chCount
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_COUNT_LE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      chCount[i] <= chLoad[i]); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (!chEn[i] && !busWe) |=> $stable(chCount[i])); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(chStatus[i]) && chOneShot[i] && !$past(busWe)) |-> !chEn[i]); // R6

    AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(chStatus[i]) && chOneShot[i] && !$past(busWe)) |-> (chCount[i] == '0)); // R6

    AST_STATUS_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chStatus[i]) |-> $past(busWe)); // R7

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[i] |-> chStatus[i]); // R8
  end

endmodule

bind dual_tick_timer timer_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .irqOut    (irqOut),
  .chStatus  (chStatus),
  .chEn      (chEn),
  .chOneShot (chOneShot),
  .chLoad    (chLoad),
  .chCount   (chCount)
);

// File: tb/dual_tick_timer_tb.sv
module dual_tick_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int EN = 32'h20;
  localparam int OS = 32'h10;
  localparam int IE = 32'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [15:0] busRdata;
  logic [1:0]  irqOut;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  dual_tick_timer u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int regAddr(input int ch, input int idx);
    return 32'h80 + ch * 32'h80 + idx * 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busAddr = 10'(a); busWdata = 16'(d); busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    busAddr = 10'(a);
    #1;
    v = int'(busRdata);
  endtask

  task automatic waitIrq(input int ch, input int stamp, output int dt);
    int guard = 0;
    while (!irqOut[ch] && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    dt = (guard >= 4000) ? -1 : cyc - stamp;
  endtask

  task automatic stopCh(input int ch);
    wr(regAddr(ch, 0), 0);
    wr(regAddr(ch, 1), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int v, st, dt, s0, s1, d0, d1, g;
    bit seen0, seen1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int ch = 0; ch < 2; ch++) begin
      for (int r = 0; r < 4; r++) begin
        rd(regAddr(ch, r), v);
        chk($sformatf("R1 reset ch%0d reg%0d", ch, r), v, 0);
      end
    end
    chk("R1 reset irq", int'(irqOut), 0);

    // R3: sweep all codes and two start values on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int code = 0; code <= 8; code++) begin
        for (int li = 0; li < 2; li++) begin
          int ld = (li == 0) ? 3 : 5;
          wr(regAddr(ch, 2), ld);
          wr(regAddr(ch, 0), code | EN | IE);
          st = cyc;
          waitIrq(ch, st, dt);
          chk($sformatf("R3 ch%0d code%0d load%0d interval", ch, code, ld), dt, ld << code);
          stopCh(ch);
        end
      end
    end

    // R11: code 12 divides as 256 and reads back as 12
    wr(regAddr(1, 2), 3);
    wr(regAddr(1, 0), 12 | EN | IE);
    st = cyc;
    rd(regAddr(1, 0), v);
    chk("R11 code readback", v & 15, 12);
    waitIrq(1, st, dt);
    chk("R11 code12 interval", dt, 3 * 256);
    stopCh(1);

    // R4: count readback mid-run, code 2, start 10
    wr(regAddr(0, 2), 10);
    wr(regAddr(0, 0), 2 | EN);
    repeat (12) @(negedge clk);
    rd(regAddr(0, 3), v);
    chk("R4 count after 3 ticks", v, 7);
    stopCh(0);
    rd(regAddr(0, 3), v);
    chk("R4 count held when disabled", v, 7);

    // R5: auto-reload
    wr(regAddr(0, 2), 20);
    wr(regAddr(0, 0), EN | IE);
    st = cyc;
    waitIrq(0, st, dt);
    chk("R5 first expiry", dt, 20);
    rd(regAddr(0, 3), v);
    chk("R5 reloaded count", v, 20);
    wr(regAddr(0, 1), 1);
    waitIrq(0, st, dt);
    chk("R5 second expiry", dt, 40);
    stopCh(0);

    // R6 / R7: one-shot and write-one-to-clear
    wr(regAddr(1, 2), 3);
    wr(regAddr(1, 0), 1 | OS | EN | IE);
    st = cyc;
    waitIrq(1, st, dt);
    chk("R6 one-shot expiry", dt, 6);
    rd(regAddr(1, 0), v);
    chk("R6 enable cleared", v, 32'h111);
    rd(regAddr(1, 3), v);
    chk("R6 count zero", v, 0);
    wr(regAddr(1, 1), 0);
    rd(regAddr(1, 1), v);
    chk("R7 write zero keeps status", v, 1);
    wr(regAddr(1, 1), 1);
    rd(regAddr(1, 1), v);
    chk("R7 write one clears status", v, 0);
    repeat (30) @(negedge clk);
    rd(regAddr(1, 1), v);
    chk("R6 no second expiry", v, 0);
    rd(regAddr(1, 3), v);
    chk("R6 count stays zero", v, 0);

    // R8: status sets with interrupt disabled; interrupt gated by enable
    wr(regAddr(0, 2), 3);
    wr(regAddr(0, 0), OS | EN);
    repeat (6) @(negedge clk);
    rd(regAddr(0, 1), v);
    chk("R8 status without irq enable", v, 1);
    chk("R8 irq low while disabled", int'(irqOut[0]), 0);
    wr(regAddr(0, 0), IE);
    chk("R8 irq follows enable", int'(irqOut[0]), 1);
    wr(regAddr(0, 1), 1);
    chk("R8 irq drops on clear", int'(irqOut[0]), 0);
    wr(regAddr(0, 0), 0);

    // R9: both channels concurrently
    wr(regAddr(0, 2), 5);
    wr(regAddr(1, 2), 3);
    wr(regAddr(0, 0), 1 | EN | IE);
    s0 = cyc;
    wr(regAddr(1, 0), 3 | EN | IE);
    s1 = cyc;
    seen0 = 0; seen1 = 0; d0 = -1; d1 = -1; g = 0;
    while (!(seen0 && seen1) && g < 2000) begin
      @(negedge clk);
      g++;
      if (irqOut[0] && !seen0) begin seen0 = 1; d0 = cyc - s0; end
      if (irqOut[1] && !seen1) begin seen1 = 1; d1 = cyc - s1; end
    end
    chk("R9 ch0 concurrent interval", d0, 10);
    chk("R9 ch1 concurrent interval", d1, 24);
    stopCh(0);
    stopCh(1);

    // R10: rewrite start value while running
    wr(regAddr(0, 2), 50);
    wr(regAddr(0, 0), EN | IE);
    repeat (10) @(negedge clk);
    wr(regAddr(0, 2), 7);
    st = cyc;
    waitIrq(0, st, dt);
    chk("R10 restart interval", dt, 7);
    stopCh(0);

    // R2: address decode and channel isolation
    wr(regAddr(1, 2), 32'h1234);
    rd(regAddr(1, 2), v);
    chk("R2 ch1 load readback", v, 32'h1234);
    rd(regAddr(0, 2), v);
    chk("R2 ch0 load untouched", v, 7);
    rd(32'h000, v);
    chk("R2 unmapped low window", v, 0);
    rd(32'h090, v);
    chk("R2 unmapped hole in window", v, 0);
    rd(32'h180, v);
    chk("R2 window beyond last channel", v, 0);

    // R12: unused control bits read zero
    wr(regAddr(0, 0), 32'hFFFF);
    rd(regAddr(0, 0), v);
    chk("R12 control reserved bits", v, 32'h13F);
    stopCh(0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule